// File: doc/BRIEF.md
# Square-Wave Perturbation Source with Ripple-Amplitude Regulation

This block produces a small square-wave test signal that is summed into a digital feedback loop. The loop's response to it can then be measured while the loop stays closed. The wave's period is set by a clock-divide count. A free-running counter and a comparator split each period into a positive half and a negative half of equal length. The output is a signed value of either +delta or -delta.

The amplitude delta regulates itself. The block watches the quantized error samples of the loop it disturbs and tracks the largest error magnitude seen during each wave period. At every period boundary it integrates the difference between a reference peak (normally one code) and that measured peak. The ripple the wave causes therefore settles at the reference, whatever the injection frequency. The integrator is held between zero and a programmable ceiling, and it does not wind up against either limit.

Top module: `pert_inject`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `delta` is 0 and `injOut` is 0.
- R2: A period lasts N clocks. N is `divCount` with its least significant bit forced to 0, and values below 2 become 2. `injOut` is +delta for clock offsets 0 to N/2-1 of a period and -delta for offsets N/2 to N-1. `injOut` is a two's-complement value one bit wider than `delta`.
- R3: `divCount` is sampled only in the last cycle of a period. A change made during a period does not alter the length or the half-split of that period.
- R4: The measured peak of a period is the largest absolute value of `errSample` (two's complement) over the cycles of that period in which `errValid` is high. The most negative code counts as magnitude 2^(ERR_W-1). The peak restarts at zero for each new period.
- R5: At each period end, an accumulator with FRAC_W fractional bits takes in `peakRef` minus the measured peak. `delta` is the accumulator's integer part. The new value appears on the first cycle of the next period.
- R6: If the sum would go negative, the accumulator is set to 0 and keeps no negative residue. One period with zero peak afterwards raises it by exactly `peakRef`.
- R7: If the sum would exceed `deltaMax` (integer part), the accumulator is set to exactly `deltaMax` and keeps no excess. A following negative error lowers it from `deltaMax`.
- R8: `delta`, and so the magnitude of `injOut`, stays constant within a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divCount | input | CNT_W | Requested period length in clocks |
| errSample | input | ERR_W | Signed quantized loop error |
| errValid | input | 1 | Strobe marking a valid error sample |
| peakRef | input | ERR_W | Target peak error magnitude |
| deltaMax | input | AMP_W | Upper limit for the amplitude |
| injOut | output | AMP_W+1 | Signed injection value, +delta or -delta |
| delta | output | AMP_W | Current injection amplitude |

## Verification
The bench builds the block with CNT_W=8, ERR_W=6, AMP_W=5 and FRAC_W=0. With no fractional bits, every period boundary moves `delta` by exactly the error, so each integration step can be seen at the port. The 6-bit error input brings the most negative code (-32) within reach of a single sample. The ceiling of 12 is low enough that one large reference step hits the upper clamp. Short periods of 2, 4, 6, 8 and 12 clocks test the half-split rule, the odd-count and minimum-count rounding, and the rule that a new count is loaded only at a period boundary.

// File: rtl/inj_pkg.sv
package inj_pkg;
  typedef struct packed {
    logic periodEnd;
    logic negHalf;
  } inj_stb_t;
endpackage

// File: rtl/inj_ctrl.sv
module inj_ctrl
  import inj_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] divCount,
  output inj_stb_t         stb
);
  localparam logic [CNT_W-1:0] MIN_N = CNT_W'(2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curN;
  logic [CNT_W-1:0] nextN;
  logic             atEnd;

  always_comb begin
    nextN = {divCount[CNT_W-1:1], 1'b0};
    if (nextN < MIN_N) nextN = MIN_N;
  end

  assign atEnd         = (cnt == curN - 1'b1);
  assign stb.periodEnd = atEnd;
  assign stb.negHalf   = (cnt >= (curN >> 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      curN <= MIN_N;
    end else if (atEnd) begin
      cnt  <= '0;
      curN <= nextN;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/inj_datapath.sv
module inj_datapath
  import inj_pkg::*;
#(
  parameter int ERR_W  = 8,
  parameter int AMP_W  = 10,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  inj_stb_t                stb,
  input  logic signed [ERR_W-1:0] errSample,
  input  logic                    errValid,
  input  logic [ERR_W-1:0]        peakRef,
  input  logic [AMP_W-1:0]        deltaMax,
  output logic signed [AMP_W:0]   injOut,
  output logic [AMP_W-1:0]        delta
);
  localparam int ACC_W = AMP_W + FRAC_W;
  localparam int SUM_W = ACC_W + ERR_W + 2;

  logic [ERR_W-1:0]        absErr;
  logic [ERR_W-1:0]        peakRun;
  logic [ERR_W-1:0]        peakSeen;
  logic [ACC_W-1:0]        acc;
  logic [ACC_W-1:0]        accNext;
  logic [ACC_W-1:0]        ceilAcc;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] ceilS;
  logic signed [AMP_W:0]   mag;

  // magnitude of the sample; most negative code maps to 2^(ERR_W-1)
  assign absErr   = errSample[ERR_W-1] ? ERR_W'(-errSample) : errSample;
  assign peakSeen = (errValid && (absErr > peakRun)) ? absErr : peakRun;

  always_ff @(posedge clk) begin
    if (!rstN)              peakRun <= '0;
    else if (stb.periodEnd) peakRun <= '0;
    else                    peakRun <= peakSeen;
  end

  // integrator with clamp at both ends, no residue kept past a limit
  always_comb begin
    ceilAcc = ACC_W'(deltaMax) << FRAC_W;
    ceilS   = SUM_W'(ceilAcc);
    sum     = SUM_W'(acc) + SUM_W'(peakRef) - SUM_W'(peakSeen);
    if (sum < 0)          accNext = '0;
    else if (sum > ceilS) accNext = ceilAcc;
    else                  accNext = ACC_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              acc <= '0;
    else if (stb.periodEnd) acc <= accNext;
  end

  assign delta  = acc[ACC_W-1:FRAC_W];
  assign mag    = {1'b0, delta};
  assign injOut = stb.negHalf ? -mag : mag;
endmodule

// File: rtl/pert_inject.sv
module pert_inject
  import inj_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ERR_W  = 8,
  parameter int AMP_W  = 10,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CNT_W-1:0]        divCount,
  input  logic signed [ERR_W-1:0] errSample,
  input  logic                    errValid,
  input  logic [ERR_W-1:0]        peakRef,
  input  logic [AMP_W-1:0]        deltaMax,
  output logic signed [AMP_W:0]   injOut,
  output logic [AMP_W-1:0]        delta
);
  inj_stb_t stb;

  inj_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .divCount (divCount),
    .stb      (stb)
  );

  inj_datapath #(.ERR_W(ERR_W), .AMP_W(AMP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .errSample (errSample),
    .errValid  (errValid),
    .peakRef   (peakRef),
    .deltaMax  (deltaMax),
    .injOut    (injOut),
    .delta     (delta)
  );
endmodule

// File: rtl/inj_chk.sv
module inj_chk #(
  parameter int AMP_W = 10
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [AMP_W-1:0]      deltaMax,
  input logic [AMP_W-1:0]      delta,
  input logic signed [AMP_W:0] injOut,
  input logic                  periodEnd
);
  // R7
  delta_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(delta) |-> (delta <= $past(deltaMax)));

  // R2
  amp_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (injOut == $signed({1'b0, delta})) || (injOut == -$signed({1'b0, delta})));

  // R8
  delta_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(delta) |-> $past(periodEnd));

  // R2
  period_start_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (injOut >= 0));
endmodule

bind pert_inject inj_chk #(.AMP_W(AMP_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .deltaMax  (deltaMax),
  .delta     (delta),
  .injOut    (injOut),
  .periodEnd (stb.periodEnd)
);

// File: tb/tb_pert_inject.sv
module tb_pert_inject;
  localparam int CNT_W = 8, ERR_W = 6, AMP_W = 5, FRAC_W = 0;
  localparam int NVEC = 16;
  // columns: divCount, valid, sample, peakRef, expected delta after period
  localparam int VEC [0:NVEC-1][0:4] = '{
    '{8, 0,   0,  1,  2}, '{8, 1,   3,  1,  0}, '{8, 1,  -1,  1,  0},
    '{8, 0,   0,  1,  1}, '{8, 1,   5,  1,  0}, '{12, 0,  0,  1,  1},
    '{12, 0,  0,  1,  2}, '{6, 0,   0,  1,  3}, '{6, 1,   1,  1,  3},
    '{7, 0,   0,  1,  4}, '{4, 0,   0,  1,  5}, '{4, 0,   0,  1,  6},
    '{4, 0,   0, 20, 12}, '{4, 1,   2,  1, 11}, '{4, 1, -32,  1,  0},
    '{4, 0,   0,  1,  1}
  };

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [CNT_W-1:0]        divCount = 8'd8;
  logic signed [ERR_W-1:0] errSample = '0;
  logic                    errValid = 1'b0;
  logic [ERR_W-1:0]        peakRef = 6'd1;
  logic [AMP_W-1:0]        deltaMax = 5'd12;
  logic signed [AMP_W:0]   injOut;
  logic [AMP_W-1:0]        delta;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pert_inject #(.CNT_W(CNT_W), .ERR_W(ERR_W), .AMP_W(AMP_W), .FRAC_W(FRAC_W)) dut (
    .clk(clk), .rstN(rstN), .divCount(divCount), .errSample(errSample),
    .errValid(errValid), .peakRef(peakRef), .deltaMax(deltaMax),
    .injOut(injOut), .delta(delta)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one period of n clocks from its first cycle; ends on the next period's first cycle
  task automatic runPeriod(input int n, input int vld, input int smp, input int d,
                           input bit divChanged);
    for (int k = 0; k < n; k++) begin
      if (k == 0 && vld != 0) begin
        errSample = ERR_W'(smp);
        errValid  = 1'b1;
      end
      if (k == n / 2 - 1) chk(injOut == d, divChanged ? "R3" : "R2", injOut, d);
      if (k == n / 2)     chk(injOut == -d, divChanged ? "R3" : "R2", injOut, -d);
      if (k == 1)         chk(delta == d, "R8", delta, d);
      @(negedge clk);
      errValid = 1'b0;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int curN, d, tries;
    repeat (3) @(negedge clk);
    chk(delta == 0, "R1", delta, 0);
    chk(injOut == 0, "R1", injOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(delta == 0, "R1", delta, 0);
    // first boundary: no samples, peak 0, delta rises by peakRef
    tries = 0;
    while (delta == 0 && tries < 20) begin @(negedge clk); tries++; end
    chk(delta == 1, "R5", delta, 1);
    curN = 8; d = 1;

    for (int i = 0; i < NVEC; i++) begin
      divCount = CNT_W'(VEC[i][0]);
      peakRef  = ERR_W'(VEC[i][3]);
      runPeriod(curN, VEC[i][1], VEC[i][2], d, (i > 0) && (VEC[i][0] != VEC[i-1][0]));
      chk(delta == VEC[i][4], (VEC[i][4] == 12) ? "R7" : (VEC[i][4] == 0) ? "R6" : "R5",
          delta, VEC[i][4]);
      d = VEC[i][4];
      curN = (VEC[i][0] / 2) * 2;
      if (curN < 2) curN = 2;
    end
    // after the clamp at 12, a single negative error lowers from the ceiling (R7)
    // after the clamp at 0, a zero-peak period adds exactly peakRef (R6); checked by last vectors

    // R2: count below 2 becomes a 2-clock period
    divCount = 8'd1;
    runPeriod(4, 0, 0, 1, 1'b1);
    chk(delta == 2, "R5", delta, 2);
    divCount = 8'd8;
    runPeriod(2, 0, 0, 2, 1'b1);
    chk(delta == 3, "R2", delta, 3);

    // R4: several samples in one period, largest magnitude wins
    for (int k = 0; k < 8; k++) begin
      errValid = (k < 3);
      errSample = (k == 0) ? 6'sd2 : (k == 1) ? -6'sd4 : 6'sd3;
      if (k == 0) chk(injOut == 3, "R2", injOut, 3);
      @(negedge clk);
    end
    errValid = 1'b0;
    chk(delta == 0, "R4", delta, 0);
    // R4: peak restarted, so a quiet period raises by peakRef again
    runPeriod(8, 0, 0, 0, 1'b0);
    chk(delta == 1, "R4", delta, 1);

    finishRun();
  end
endmodule